// File: doc/BRIEF.md
# DIMM Pair Error Resolver

When a memory error is reported against a chip-select, that chip-select can stand for one DIMM or for a pair of DIMMs that together form a 128-bit wide channel. This block works out which member of the pair is to blame. It takes these inputs:

- the identifiers of the two DIMMs behind the chip-select;
- the ECC scheme in use, which is either 64/8 per-half protection or symbol-based protection;
- the physical address of the failing access and the lowest address bit known to be valid;
- whether the error was correctable;
- for a correctable symbol error, the decoded symbol's top bit position and its kind (data or check).

A request is presented with a one-cycle strobe. One clock later the block gives back one of two things: a 2-bit DIMM select, or an error code saying why no answer can be given. The select has bit 0 for the lower DIMM and bit 1 for the upper DIMM. The syndrome-to-symbol decoding is done upstream of this block.

Top module: `dimm_pair_resolver`

## Requirements
- R1: If both DIMM identifiers equal the invalid value (all ones), the result is an error with code 1 (configuration) and a select of 00.
- R2: If exactly one DIMM identifier is valid, the select is 01 with no error. This holds whatever the ECC mode, address or symbol inputs are.
- R3: In 64/8 mode (ecc_sym_mode = 0) with two valid DIMMs and low_valid_bit <= 3, the select is 10 when phys_addr[3] is 1 and 01 when it is 0.
- R4: In 64/8 mode with two valid DIMMs and low_valid_bit > 3, the result is an error with code 2 (insufficient resolution).
- R5: In symbol mode (ecc_sym_mode = 1) with two valid DIMMs and a correctable error, the select is 01 in two cases: a data symbol with top bit <= 63, or a check symbol with top bit <= 7. In every other case it is 10.
- R6: In symbol mode with two valid DIMMs and an uncorrectable error, the select is 11. The symbol inputs are ignored.
- R7: In symbol mode with two valid DIMMs, a correctable error whose symbol is marked neither data nor check gives an error with code 3 (invalid syndrome).
- R8: Whenever res_err is 1, res_sel is 00. Whenever res_err is 0, res_code is 0.
- R9: res_valid is high for exactly the cycle after each strobe, and the results are registered at that same edge. A synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| id_lo | input | ID_W | Identifier of the first (lower) DIMM; all ones means absent |
| id_hi | input | ID_W | Identifier of the second (upper) DIMM; all ones means absent |
| ecc_sym_mode | input | 1 | 0 = 64/8 ECC, 1 = symbol ECC |
| phys_addr | input | ADDR_W | Physical address of the failing access |
| low_valid_bit | input | LSB_W | Lowest valid address bit position |
| err_corr | input | 1 | Error was correctable |
| sym_top_bit | input | BIT_W | Highest bit covered by the decoded symbol |
| sym_is_data | input | 1 | Decoded symbol covers data bits |
| sym_is_check | input | 1 | Decoded symbol covers check bits |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_sel | output | 2 | DIMM select: bit 0 lower, bit 1 upper |
| res_err | output | 1 | No DIMM could be resolved |
| res_code | output | 2 | Error cause: 1 configuration, 2 resolution, 3 syndrome |

## Verification
The hardest decisions to reach are the ones that sit exactly on a threshold. Examples are a data symbol with top bit 63 or 64, a check symbol with top bit 7 or 8, and a lowest valid bit of exactly 3 or 4.

Uniform random inputs rarely land on these values, so the random generator biases its draws toward them. It also draws the invalid identifier often enough to cover the zero-DIMM and one-DIMM paths in both modes. Directed cases then pin down each threshold pair, along with a symbol marked neither data nor check.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CFG  = 2'd1,
    ERR_RES  = 2'd2,
    ERR_SYN  = 2'd3
  } dpr_err_e;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_LO   = 2'b01;
  localparam logic [1:0] SEL_HI   = 2'b10;
  localparam logic [1:0] SEL_BOTH = 2'b11;

  typedef struct packed {
    logic [1:0] sel;
    logic       err;
    dpr_err_e   code;
  } dpr_res_t;
endpackage

// File: rtl/dpr_count.sv
module dpr_count #(
  parameter int ID_W = 4
) (
  input  logic [ID_W-1:0] id_lo,
  input  logic [ID_W-1:0] id_hi,
  output logic [1:0]      n_ok
);
  localparam logic [ID_W-1:0] ID_ABSENT = '1;

  logic [1:0][ID_W-1:0] ids;
  logic [1:0]           present;

  assign ids = {id_hi, id_lo};

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assign present[g] = (ids[g] != ID_ABSENT);
  end

  assign n_ok = {1'b0, present[0]} + {1'b0, present[1]};
endmodule

// File: rtl/dpr_addr_split.sv
module dpr_addr_split
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int LSB_W     = 6,
  parameter int SPLIT_BIT = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LSB_W-1:0]  low_valid,
  output dpr_res_t          res
);
  localparam logic [LSB_W-1:0] SPLIT_L = LSB_W'(SPLIT_BIT);

  logic unused_addr;
  assign unused_addr = ^{addr[ADDR_W-1:SPLIT_BIT+1], addr[SPLIT_BIT-1:0]};

  always_comb begin
    if (low_valid <= SPLIT_L) begin
      res.sel  = addr[SPLIT_BIT] ? SEL_HI : SEL_LO;
      res.err  = 1'b0;
      res.code = ERR_NONE;
    end else begin
      res.sel  = SEL_NONE;
      res.err  = 1'b1;
      res.code = ERR_RES;
    end
  end
endmodule

// File: rtl/dpr_sym_split.sv
module dpr_sym_split
  import dpr_pkg::*;
#(
  parameter int BIT_W     = 7,
  parameter int DATA_TOP  = 63,
  parameter int CHECK_TOP = 7
) (
  input  logic             corr,
  input  logic [BIT_W-1:0] top_bit,
  input  logic             is_data,
  input  logic             is_check,
  output dpr_res_t         res
);
  localparam logic [BIT_W-1:0] DATA_L  = BIT_W'(DATA_TOP);
  localparam logic [BIT_W-1:0] CHECK_L = BIT_W'(CHECK_TOP);

  logic in_lower;
  assign in_lower = (is_data && (top_bit <= DATA_L)) ||
                    (is_check && (top_bit <= CHECK_L));

  always_comb begin
    res.sel  = SEL_NONE;
    res.err  = 1'b0;
    res.code = ERR_NONE;
    if (!corr) begin
      res.sel = SEL_BOTH;
    end else if (!is_data && !is_check) begin
      res.err  = 1'b1;
      res.code = ERR_SYN;
    end else begin
      res.sel = in_lower ? SEL_LO : SEL_HI;
    end
  end
endmodule

// File: rtl/dimm_pair_resolver.sv
module dimm_pair_resolver
  import dpr_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 40,
  parameter int LSB_W     = 6,
  parameter int BIT_W     = 7,
  parameter int SPLIT_BIT = 3,
  parameter int DATA_TOP  = 63,
  parameter int CHECK_TOP = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   id_lo,
  input  logic [ID_W-1:0]   id_hi,
  input  logic              ecc_sym_mode,
  input  logic [ADDR_W-1:0] phys_addr,
  input  logic [LSB_W-1:0]  low_valid_bit,
  input  logic              err_corr,
  input  logic [BIT_W-1:0]  sym_top_bit,
  input  logic              sym_is_data,
  input  logic              sym_is_check,
  output logic              res_valid,
  output logic [1:0]        res_sel,
  output logic              res_err,
  output logic [1:0]        res_code
);
  localparam logic [ID_W-1:0] ID_ABSENT = '1;

  logic [1:0] n_ok;
  dpr_res_t   addr_res, sym_res, pick;

  dpr_count #(.ID_W(ID_W)) u_count (
    .id_lo(id_lo), .id_hi(id_hi), .n_ok(n_ok)
  );

  dpr_addr_split #(.ADDR_W(ADDR_W), .LSB_W(LSB_W), .SPLIT_BIT(SPLIT_BIT)) u_addr (
    .addr(phys_addr), .low_valid(low_valid_bit), .res(addr_res)
  );

  dpr_sym_split #(.BIT_W(BIT_W), .DATA_TOP(DATA_TOP), .CHECK_TOP(CHECK_TOP)) u_sym (
    .corr(err_corr), .top_bit(sym_top_bit), .is_data(sym_is_data),
    .is_check(sym_is_check), .res(sym_res)
  );

  always_comb begin
    if (n_ok == 2'd0) begin
      pick.sel  = SEL_NONE;
      pick.err  = 1'b1;
      pick.code = ERR_CFG;
    end else if (n_ok == 2'd1) begin
      pick.sel  = SEL_LO;
      pick.err  = 1'b0;
      pick.code = ERR_NONE;
    end else if (ecc_sym_mode) begin
      pick = sym_res;
    end else begin
      pick = addr_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_sel   <= SEL_NONE;
      res_err   <= 1'b0;
      res_code  <= ERR_NONE;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_sel  <= pick.sel;
        res_err  <= pick.err;
        res_code <= pick.code;
      end
    end
  end

  AST_NO_DIMM_CFG: assert property (@(posedge clk) disable iff (rst)
    req_valid && id_lo == ID_ABSENT && id_hi == ID_ABSENT
    |=> res_err && res_code == 2'd1); // R1
  AST_SINGLE_LO: assert property (@(posedge clk) disable iff (rst)
    req_valid && ((id_lo == ID_ABSENT) != (id_hi == ID_ABSENT))
    |=> !res_err && res_sel == 2'b01); // R2
  AST_UNCORR_BOTH: assert property (@(posedge clk) disable iff (rst)
    req_valid && id_lo != ID_ABSENT && id_hi != ID_ABSENT && ecc_sym_mode && !err_corr
    |=> res_sel == 2'b11 && !res_err); // R6
  AST_ERR_NOSEL: assert property (@(posedge clk) disable iff (rst)
    res_err |-> res_sel == 2'b00 && res_code != 2'd0); // R8
  AST_STROBE_LAT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid); // R9
endmodule

// File: tb/sim_dimm_pair_resolver.sv
module sim_dimm_pair_resolver;
  localparam int CLK_P = 10;
  localparam int ID_W = 4, ADDR_W = 40, LSB_W = 6, BIT_W = 7;
  localparam logic [ID_W-1:0] ABS = '1;

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [ID_W-1:0] id_lo = '0, id_hi = '0;
  logic ecc_sym_mode = 1'b0, err_corr = 1'b0, sym_is_data = 1'b0, sym_is_check = 1'b0;
  logic [ADDR_W-1:0] phys_addr = '0;
  logic [LSB_W-1:0] low_valid_bit = '0;
  logic [BIT_W-1:0] sym_top_bit = '0;
  logic res_valid, res_err;
  logic [1:0] res_sel, res_code;

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  dimm_pair_resolver u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .id_lo(id_lo), .id_hi(id_hi),
    .ecc_sym_mode(ecc_sym_mode), .phys_addr(phys_addr), .low_valid_bit(low_valid_bit),
    .err_corr(err_corr), .sym_top_bit(sym_top_bit), .sym_is_data(sym_is_data),
    .sym_is_check(sym_is_check), .res_valid(res_valid), .res_sel(res_sel),
    .res_err(res_err), .res_code(res_code)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // expected {sel, err, code} and the requirement tag that decides it
  function automatic logic [4:0] model(output string tag);
    int n;
    n = (id_lo != ABS) + (id_hi != ABS);
    if (n == 0) begin tag = "R1"; return {2'b00, 1'b1, 2'd1}; end
    if (n == 1) begin tag = "R2"; return {2'b01, 1'b0, 2'd0}; end
    if (!ecc_sym_mode) begin
      if (low_valid_bit <= 3) begin
        tag = "R3"; return {phys_addr[3] ? 2'b10 : 2'b01, 1'b0, 2'd0};
      end
      tag = "R4"; return {2'b00, 1'b1, 2'd2};
    end
    if (!err_corr) begin tag = "R6"; return {2'b11, 1'b0, 2'd0}; end
    if (!sym_is_data && !sym_is_check) begin tag = "R7"; return {2'b00, 1'b1, 2'd3}; end
    tag = "R5";
    if ((sym_is_data && sym_top_bit <= 63) || (sym_is_check && sym_top_bit <= 7))
      return {2'b01, 1'b0, 2'd0};
    return {2'b10, 1'b0, 2'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req();
    string tag;
    logic [4:0] exp;
    exp = model(tag);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", {31'd0, res_valid}, 32'd1);
    check(tag, {27'd0, res_sel, res_err, res_code}, {27'd0, exp});
    if (exp[2]) check("R8", {30'd0, res_sel}, 32'd0);
    @(negedge clk);
    check("R9", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic set_req(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b, input logic m,
                         input logic [ADDR_W-1:0] pa, input logic [LSB_W-1:0] lv,
                         input logic c, input logic [BIT_W-1:0] tb, input logic d, input logic k);
    id_lo = a; id_hi = b; ecc_sym_mode = m; phys_addr = pa; low_valid_bit = lv;
    err_corr = c; sym_top_bit = tb; sym_is_data = d; sym_is_check = k;
  endtask

  function automatic logic [BIT_W-1:0] pick_bit();
    int r = $urandom % 8;
    if (r == 0) return 7'd63;
    if (r == 1) return 7'd64;
    if (r == 2) return 7'd7;
    if (r == 3) return 7'd8;
    return BIT_W'($urandom % 128);
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R9", {28'd0, res_valid, res_err, res_sel}, 32'd0);
    check("R9", {30'd0, res_code}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // directed corner cases
    set_req(ABS, ABS, 1'b0, 40'h8, 6'd0, 1'b1, 7'd0, 1'b1, 1'b0); run_req(); // R1
    set_req(4'd2, ABS, 1'b1, 40'h8, 6'd9, 1'b0, 7'd90, 1'b0, 1'b0); run_req(); // R2
    set_req(ABS, 4'd5, 1'b0, 40'h8, 6'd9, 1'b1, 7'd0, 1'b0, 1'b0); run_req(); // R2
    set_req(4'd1, 4'd2, 1'b0, 40'h8, 6'd3, 1'b1, 7'd0, 1'b0, 1'b0); run_req(); // R3
    set_req(4'd1, 4'd2, 1'b0, 40'h7, 6'd3, 1'b1, 7'd0, 1'b0, 1'b0); run_req(); // R3
    set_req(4'd1, 4'd2, 1'b0, 40'h8, 6'd4, 1'b1, 7'd0, 1'b0, 1'b0); run_req(); // R4
    set_req(4'd1, 4'd2, 1'b1, 40'h0, 6'd0, 1'b1, 7'd63, 1'b1, 1'b0); run_req(); // R5
    set_req(4'd1, 4'd2, 1'b1, 40'h0, 6'd0, 1'b1, 7'd64, 1'b1, 1'b0); run_req(); // R5
    set_req(4'd1, 4'd2, 1'b1, 40'h0, 6'd0, 1'b1, 7'd7, 1'b0, 1'b1); run_req(); // R5
    set_req(4'd1, 4'd2, 1'b1, 40'h0, 6'd0, 1'b1, 7'd8, 1'b0, 1'b1); run_req(); // R5
    set_req(4'd1, 4'd2, 1'b1, 40'h0, 6'd0, 1'b0, 7'd0, 1'b0, 1'b0); run_req(); // R6
    set_req(4'd1, 4'd2, 1'b1, 40'h0, 6'd0, 1'b1, 7'd3, 1'b0, 1'b0); run_req(); // R7

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [ID_W-1:0] a, b;
      a = ($urandom % 4 == 0) ? ABS : ID_W'($urandom % 15);
      b = ($urandom % 4 == 0) ? ABS : ID_W'($urandom % 15);
      set_req(a, b, 1'($urandom), {8'($urandom), $urandom},
              LSB_W'($urandom % 8), ($urandom % 3 != 0), pick_bit(),
              1'($urandom), 1'($urandom));
      run_req();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule